// File: doc/BRIEF.md
# Vectored Interrupt Priority Controller

This block gathers interrupt conditions from fourteen on-chip sources and one external bus requester, and presents them to a processor that fetches an 8-bit vector during its interrupt acknowledge. The sources are a raster line event, two serial receivers, eight timer channels, the video frame event and two serial transmitters. Each source gets a sticky status bit that software clears by writing ones, and an enable that decides whether the source may interrupt or is only polled.

The controller has two modes. In pulse mode an enabled source gives a single-cycle interrupt pulse and no vector is produced. In vectored mode each enabled source keeps a pending request until the processor acknowledges it. On the acknowledge strobe the controller captures the vector of the winning source and retires that request, so the next one can follow. The vector carries a programmable 3-bit base in its top bits, the source code in bits 4:1, and a zero in bit 0. External requests rank below every internal source. They take the vector offered on the bus, or 0xFF when none is offered.

Top module: `im2_prio_ctrl`

## Requirements
- R1: An acknowledge in vectored mode that selects internal source k latches the vector {base[2:0], k[3:0], 1'b0}, and the vector holds until the next such acknowledge.
- R2: Among pending enabled sources the lowest code wins. The codes are 0 line, 1 and 2 serial receive 0 and 1, 3 to 10 timers 0 to 7, 11 frame, 12 and 13 serial transmit 0 and 1.
- R3: With no internal source pending, an acknowledge latches ext_vec when ext_vec_valid is 1 and 0xFF otherwise. ext_req raises int_req in vectored mode.
- R4: In pulse mode, int_req is high for exactly the one cycle after the clock edge that sees an enabled condition rise. In vectored mode int_req is high while any enabled request is pending or ext_req is high.
- R5: A rising condition sets its status bit whether or not it is enabled. Writing a 1 to a bit of status_clr clears that bit, unless a new rise arrives in the same cycle.
- R6: In vectored mode a status bit keeps reading 1 after a clear while its request is still pending. It reads 0 once the request has been acknowledged.
- R7: Receiver near-full (rx_nfull) and data-available (src_cond bits 1 and 2) share one source per receiver. Either one alone raises that source.
- R8: A disabled source raises no interrupt, but its status still latches.
- R9: An acknowledge retires only the winning request, so the next pending source is presented afterwards.
- R10: After reset the base is 000, the mode is pulse, status is 0, int_req is 0 and the vector reads 0xFF. cfg_we loads the base and the mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Load cfg_base and cfg_im2 |
| cfg_base | input | 3 | Vector base bits 7:5 |
| cfg_im2 | input | 1 | 1 selects vectored mode, 0 selects pulse mode |
| src_cond | input | 14 | Per-source condition level, one bit per code |
| rx_nfull | input | 2 | Receiver near-full, merged into codes 1 and 2 |
| src_en | input | 14 | Per-source interrupt enable |
| status_clr | input | 14 | Write-one-to-clear strobe for status |
| ext_req | input | 1 | External bus interrupt request |
| ext_vec_valid | input | 1 | External requester is driving a vector |
| ext_vec | input | 8 | Vector offered by the external bus |
| ack | input | 1 | Interrupt acknowledge strobe |
| int_req | output | 1 | Interrupt request to the processor |
| vector | output | 8 | Vector latched at acknowledge |
| status | output | 14 | Sticky per-source status |

## Verification
The bench raises several sources in the same cycle and acknowledges them one at a time. A broken priority encoder would present them in the wrong order, and an acknowledge that cleared every request would let later sources vanish. It clears a status bit while the request is still pending in vectored mode, which catches a design that lets the clear win. It raises a disabled source, which catches a design that gates the status latch with the enable or lets the source interrupt. It also acknowledges with nothing pending, with and without an external vector, and with an internal source competing against the bus, which catches the wrong idle value and external requests placed too high.

// File: rtl/im2_prio_ctrl.sv
module im2_prio_ctrl #(
  parameter int NSRC  = 14,
  parameter int NUART = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_we,
  input  logic [2:0]      cfg_base,
  input  logic            cfg_im2,
  input  logic [NSRC-1:0] src_cond,
  input  logic [NUART-1:0] rx_nfull,
  input  logic [NSRC-1:0] src_en,
  input  logic [NSRC-1:0] status_clr,
  input  logic            ext_req,
  input  logic            ext_vec_valid,
  input  logic [7:0]      ext_vec,
  input  logic            ack,
  output logic            int_req,
  output logic [7:0]      vector,
  output logic [NSRC-1:0] status
);
  localparam int CW = $clog2(NSRC);

  logic [NSRC-1:0] cond, cond_d, rise, status_q, pend_q, act, win;
  logic [2:0]      base_q;
  logic            im2_q, pulse_q, hit;
  logic [CW-1:0]   code;

  assign cond = src_cond | NSRC'({rx_nfull, 1'b0});
  assign rise = cond & ~cond_d;
  assign act  = pend_q & src_en;

  always_comb begin
    win  = '0;
    code = '0;
    hit  = 1'b0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (act[i]) begin
        win    = '0;
        win[i] = 1'b1;
        code   = CW'(i);
        hit    = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cond_d   <= '0;
      status_q <= '0;
      pend_q   <= '0;
      pulse_q  <= 1'b0;
      base_q   <= 3'b000;
      im2_q    <= 1'b0;
      vector   <= 8'hFF;
    end else begin
      cond_d   <= cond;
      status_q <= (status_q & ~status_clr) | rise;
      pulse_q  <= |(rise & src_en);
      if (im2_q) pend_q <= (pend_q & ~(ack ? win : '0)) | (rise & src_en);
      else       pend_q <= '0;
      if (im2_q && ack)
        vector <= hit ? {base_q, code, 1'b0} : (ext_vec_valid ? ext_vec : 8'hFF);
      if (cfg_we) begin
        base_q <= cfg_base;
        im2_q  <= cfg_im2;
      end
    end
  end

  assign int_req = im2_q ? (hit | ext_req) : pulse_q;
  assign status  = status_q | (im2_q ? pend_q : '0);

  AST_ONE_WINNER: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(win)); // R2
  AST_VEC_FORMAT: assert property (@(posedge clk) disable iff (!rst_n)
    (im2_q && ack && hit) |=> (vector[0] == 1'b0 && vector[7:5] == $past(base_q)
                               && vector[4:1] == $past(code))); // R1
  AST_IDLE_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
    (im2_q && ack && !hit && !ext_vec_valid) |=> (vector == 8'hFF)); // R3
  AST_ACK_RETIRES: assert property (@(posedge clk) disable iff (!rst_n)
    (im2_q && ack && hit) |=> ((pend_q & $past(win & ~(rise & src_en))) == '0)); // R9
  AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (|rise) |=> ((status_q & $past(rise)) == $past(rise))); // R5
endmodule

// File: tb/im2_prio_ctrl_bench.sv
module im2_prio_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0, cfg_im2 = 1'b0;
  logic [2:0]  cfg_base = 3'b0;
  logic [13:0] src_cond = '0, src_en = '0, status_clr = '0;
  logic [1:0]  rx_nfull = '0;
  logic        ext_req = 1'b0, ext_vec_valid = 1'b0, ack = 1'b0;
  logic [7:0]  ext_vec = 8'h00;
  logic        int_req;
  logic [7:0]  vector;
  logic [13:0] status;

  int checks = 0, fails = 0;
  bit done = 0;
  string tag = "R10";

  always #4 clk = ~clk;

  im2_prio_ctrl u_im2_prio_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_base(cfg_base), .cfg_im2(cfg_im2),
    .src_cond(src_cond), .rx_nfull(rx_nfull), .src_en(src_en), .status_clr(status_clr),
    .ext_req(ext_req), .ext_vec_valid(ext_vec_valid), .ext_vec(ext_vec), .ack(ack),
    .int_req(int_req), .vector(vector), .status(status)
  );

  // behavioural reference model
  logic [13:0] m_cd, m_st, m_pd;
  logic        m_pl, m_im2;
  logic [7:0]  m_vec;
  logic [2:0]  m_base;

  always @(posedge clk) begin
    logic [13:0] c, r, wm;
    int w;
    if (!rst_n) begin
      m_cd = '0; m_st = '0; m_pd = '0; m_pl = 0; m_im2 = 0; m_vec = 8'hFF; m_base = 0;
    end else begin
      c = src_cond; c[1] = c[1] | rx_nfull[0]; c[2] = c[2] | rx_nfull[1];
      r = c & ~m_cd;
      w = -1;
      for (int i = 0; i < 14; i++) if (w < 0 && m_pd[i] && src_en[i]) w = i;
      wm = '0;
      if (ack && m_im2) begin
        if (w >= 0) begin m_vec = {m_base, 4'(w), 1'b0}; wm[w] = 1'b1; end
        else m_vec = ext_vec_valid ? ext_vec : 8'hFF;
      end
      m_pd = m_im2 ? ((m_pd & ~wm) | (r & src_en)) : '0;
      m_st = (m_st & ~status_clr) | r;
      m_pl = |(r & src_en);
      if (cfg_we) begin m_base = cfg_base; m_im2 = cfg_im2; end
      m_cd = c;
    end
  end

  task automatic chk(input string t, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", t, act, exp);
    end
  endtask

  task automatic tick();
    logic e_int;
    @(posedge clk); #2;
    e_int = m_im2 ? ((|(m_pd & src_en)) | ext_req) : m_pl;
    chk({tag, " int_req"}, 32'(int_req), 32'(e_int));
    chk({tag, " vector"}, 32'(vector), 32'(m_vec));
    chk({tag, " status"}, 32'(status), 32'(m_st | (m_im2 ? m_pd : 14'h0)));
    ack = 0; status_clr = '0; cfg_we = 0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    tag = "R10"; tick();
    chk("R10 reset vector", 32'(vector), 32'hFF);
    chk("R10 reset int_req", 32'(int_req), 0);
    chk("R10 reset status", 32'(status), 0);

    tag = "R4"; src_en = '1; src_cond[6] = 1; tick();
    chk("R4 pulse high", 32'(int_req), 1);
    chk("R5 status latched", 32'(status[6]), 1);
    src_cond = '0; tick();
    chk("R4 pulse one cycle", 32'(int_req), 0);
    tag = "R5"; status_clr[6] = 1; tick();
    chk("R5 w1c clears", 32'(status[6]), 0);

    tag = "R8"; src_en[0] = 0; src_cond[0] = 1; tick();
    chk("R8 disabled no int", 32'(int_req), 0);
    chk("R8 status latched", 32'(status[0]), 1);
    src_cond = '0; status_clr = 14'h1; tick(); tick();
    src_en = '1;

    tag = "R1"; cfg_we = 1; cfg_im2 = 1; cfg_base = 3'b101; tick();
    src_cond[6] = 1; src_cond[11] = 1; src_cond[13] = 1; tick();
    src_cond = '0;
    chk("R4 im2 level", 32'(int_req), 1);
    tag = "R2"; ack = 1; tick();
    chk("R1 R2 first vector", 32'(vector), 32'hAC);
    tag = "R9"; ack = 1; tick();
    chk("R9 second vector", 32'(vector), 32'hB6);
    ack = 1; tick();
    chk("R9 third vector", 32'(vector), 32'hBA);
    chk("R9 all retired", 32'(int_req), 0);
    status_clr = '1; tick();

    tag = "R6"; src_cond[12] = 1; tick(); src_cond = '0;
    status_clr[12] = 1; tick();
    chk("R6 stays while pending", 32'(status[12]), 1);
    ack = 1; tick();
    chk("R6 vector", 32'(vector), 32'hB8);
    chk("R6 released after ack", 32'(status[12]), 0);

    tag = "R7"; rx_nfull[1] = 1; tick(); rx_nfull = '0;
    ack = 1; tick();
    chk("R7 near-full source", 32'(vector), 32'hA4);
    src_cond[1] = 1; tick(); src_cond = '0;
    ack = 1; tick();
    chk("R7 available source", 32'(vector), 32'hA2);
    status_clr = '1; tick();

    tag = "R3"; ext_req = 1; ext_vec_valid = 1; ext_vec = 8'h42; tick();
    chk("R3 ext raises int", 32'(int_req), 1);
    ack = 1; tick();
    chk("R3 ext vector", 32'(vector), 32'h42);
    ext_vec_valid = 0; ack = 1; tick();
    chk("R3 idle 0xFF", 32'(vector), 32'hFF);
    ext_vec_valid = 1; src_cond[3] = 1; tick(); src_cond = '0;
    ack = 1; tick();
    chk("R3 internal beats ext", 32'(vector), 32'hA6);
    ext_req = 0; ext_vec_valid = 0;

    tag = "R10"; cfg_we = 1; cfg_im2 = 0; cfg_base = 3'b010; tick();
    src_cond[13] = 1; tick(); src_cond = '0;
    chk("R10 back to pulse", 32'(int_req), 1);
    tick();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule